// File: doc/BRIEF.md
# Multi-Pipe Interrupt Aggregator

This block gathers interrupt conditions from a set of data pipes and from a handful of engine-wide events, then drives one level interrupt line toward a single execution environment. Every pipe owns a sticky status word, an enable word and a write-one-to-clear strobe. The engine-wide events have their own status, enable and clear registers. Status bits record every event, enabled or not. Only enabled bits count toward the summary.

The summary is built in two levels. A pipe with any enabled pending bit sets its own bit in a source word. Any enabled pending global bit sets bit 31 of the same word. A mask register then decides which source bits may drive the output. The output runs through a two-state machine. IRQ_QUIET moves to IRQ_RAISED on the RAISE transition, taken when a masked source bit is set. IRQ_RAISED returns to IRQ_QUIET on the DROP transition, taken once no masked source bit remains.

Software reaches every register through one word-wide register port. Writes take effect on the clock edge, and reads return the addressed word combinationally.

Top module: `irq_aggregator`

## Requirements
- R1: After reset, every status word, every pipe enable word and the mask are zero, the global enable reads 0x06 (error at bit 2 and bus response error at bit 1 enabled), and irq_o is low.
- R2: A pipe event pulse on pipe p bit b sets bit b of that pipe's status word (address 0x10+4p) on the next edge, whatever its enable, and the bit stays set until cleared.
- R3: Global event inputs latch into global status (address 0x00) at bit 4 = timer, bit 3 = empty, bit 2 = error, bit 1 = bus response error; input bit 0 is ignored and status bit 0 always reads 0.
- R4: Writing to a clear address (global 0x02, pipe 0x10+4p+2) clears exactly the status bits written as 1; bits written as 0 keep their value; clear addresses read as 0.
- R5: When an event and a clear hit the same status bit in the same cycle, the bit ends set.
- R6: Source word (address 0x03) bit p is 1 exactly when pipe p's status ANDed with its enable word (address 0x10+4p+1, 6 bits) is non-zero; source bits from NPIPE to 30 read 0.
- R7: Source bit 31 is 1 exactly when global status ANDed with global enable (address 0x01, bits 4..1 writable) is non-zero.
- R8: irq_o equals, one edge later, the OR of the source word ANDed with the mask (address 0x04; bits 0..NPIPE-1 and bit 31 writable), and stays high while such a bit remains set.
- R9: Writes to read-only addresses (global status, source, pipe status) and to unmapped addresses change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pipe_evt_i | input | NPIPE*PEV_W | Event pulses; pipe p uses bits [p*PEV_W +: PEV_W] |
| glb_evt_i | input | 5 | Global event pulses; bits 4..1 used, bit 0 ignored |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register word address for read and write |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Combinational read data for reg_addr_i |
| irq_o | output | 1 | Level interrupt, active high |

## Verification
An event or a write presented before edge k shows in status, enable, mask and source readback straight after edge k, because read data is combinational from those registers. irq_o trails by one more edge: it reflects the masked source as it stood just before edge k+1. The bench's reference model updates at each rising edge from the inputs it drove. It computes the new irq value from the model state before that update. It compares irq_o and the read word at the following falling edge, so every comparison lands in exactly the cycle the result is due.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    localparam int REG_W       = 32;
    localparam int GLB_W       = 5;
    localparam int SRC_GLB_BIT = 31;

    // global status layout: 4 timer, 3 empty, 2 error, 1 bus response error
    localparam logic [GLB_W-1:0] GLB_VALID      = 5'b11110;
    localparam logic [GLB_W-1:0] GLB_EN_DEFAULT = 5'b00110;

    // word addresses
    localparam int OFS_GSTAT   = 0;
    localparam int OFS_GEN     = 1;
    localparam int OFS_GCLR    = 2;
    localparam int OFS_SRC     = 3;
    localparam int OFS_MASK    = 4;
    localparam int PIPE_BASE   = 16;
    localparam int PIPE_STRIDE = 4;
    localparam int POFS_STAT   = 0;
    localparam int POFS_EN     = 1;
    localparam int POFS_CLR    = 2;

    typedef enum logic {
        IRQ_QUIET,
        IRQ_RAISED
    } irq_state_e;

endpackage

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
    parameter int             W      = 6,
    parameter logic [W-1:0]   VALID  = '1,
    parameter logic [W-1:0]   EN_RST = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt_i,
    input  logic         en_we_i,
    input  logic         clr_we_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] stat_o,
    output logic [W-1:0] en_o,
    output logic         pend_o
);

    logic [W-1:0] stat_q;
    logic [W-1:0] en_q;
    logic [W-1:0] kept;

    // clear first, then OR the new events so a same-cycle event survives
    always_comb begin
        kept = clr_we_i ? (stat_q & ~wdata_i) : stat_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
            en_q   <= EN_RST & VALID;
        end else begin
            stat_q <= (kept | evt_i) & VALID;
            if (en_we_i) begin
                en_q <= wdata_i & VALID;
            end
        end
    end

    assign stat_o = stat_q;
    assign en_o   = en_q;
    assign pend_o = |(stat_q & en_q);

endmodule

// File: rtl/irq_out_fsm.sv
module irq_out_fsm
    import irq_agg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hit_i,
    output logic irq_o
);

    irq_state_e state_q;
    irq_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= IRQ_QUIET;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_QUIET:  if (hit_i)  state_d = IRQ_RAISED;  // RAISE
            IRQ_RAISED: if (!hit_i) state_d = IRQ_QUIET;   // DROP
            default:    state_d = IRQ_QUIET;
        endcase
    end

    always_comb begin
        irq_o = (state_q == IRQ_RAISED);
    end

endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
    import irq_agg_pkg::*;
#(
    parameter int NPIPE  = 4,
    parameter int PEV_W  = 6,
    parameter int ADDR_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NPIPE*PEV_W-1:0] pipe_evt_i,
    input  logic [GLB_W-1:0]       glb_evt_i,
    input  logic                   reg_we_i,
    input  logic [ADDR_W-1:0]      reg_addr_i,
    input  logic [REG_W-1:0]       reg_wdata_i,
    output logic [REG_W-1:0]       reg_rdata_o,
    output logic                   irq_o
);

    localparam logic [REG_W-1:0] MASK_VALID =
        (REG_W'(1) << SRC_GLB_BIT) | ((REG_W'(1) << NPIPE) - REG_W'(1));

    function automatic logic [ADDR_W-1:0] glb_addr(input int ofs);
        return ADDR_W'(ofs);
    endfunction

    function automatic logic [ADDR_W-1:0] pipe_addr(input int p, input int ofs);
        return ADDR_W'(PIPE_BASE + PIPE_STRIDE * p + ofs);
    endfunction

    logic [GLB_W-1:0] glb_stat;
    logic [GLB_W-1:0] glb_en;
    logic             glb_pend;
    logic [PEV_W-1:0] pipe_stat [NPIPE];
    logic [PEV_W-1:0] pipe_en   [NPIPE];
    logic [NPIPE-1:0] pipe_pend;
    logic [REG_W-1:0] src_word;
    logic [REG_W-1:0] mask_q;
    logic             masked_hit;

    // global bank
    irq_status_bank #(
        .W      (GLB_W),
        .VALID  (GLB_VALID),
        .EN_RST (GLB_EN_DEFAULT)
    ) u_glb (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_i    (glb_evt_i),
        .en_we_i  (reg_we_i && reg_addr_i == glb_addr(OFS_GEN)),
        .clr_we_i (reg_we_i && reg_addr_i == glb_addr(OFS_GCLR)),
        .wdata_i  (reg_wdata_i[GLB_W-1:0]),
        .stat_o   (glb_stat),
        .en_o     (glb_en),
        .pend_o   (glb_pend)
    );

    // one bank per pipe
    for (genvar p = 0; p < NPIPE; p++) begin : g_pipe
        irq_status_bank #(
            .W      (PEV_W),
            .VALID  ({PEV_W{1'b1}}),
            .EN_RST ({PEV_W{1'b0}})
        ) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .evt_i    (pipe_evt_i[p*PEV_W +: PEV_W]),
            .en_we_i  (reg_we_i && reg_addr_i == pipe_addr(p, POFS_EN)),
            .clr_we_i (reg_we_i && reg_addr_i == pipe_addr(p, POFS_CLR)),
            .wdata_i  (reg_wdata_i[PEV_W-1:0]),
            .stat_o   (pipe_stat[p]),
            .en_o     (pipe_en[p]),
            .pend_o   (pipe_pend[p])
        );
    end

    // environment mask
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (reg_we_i && reg_addr_i == glb_addr(OFS_MASK)) begin
            mask_q <= reg_wdata_i & MASK_VALID;
        end
    end

    // source summary word
    always_comb begin
        src_word = '0;
        src_word[NPIPE-1:0]   = pipe_pend;
        src_word[SRC_GLB_BIT] = glb_pend;
    end

    assign masked_hit = |(src_word & mask_q);

    irq_out_fsm u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .hit_i (masked_hit),
        .irq_o (irq_o)
    );

    // readback
    always_comb begin
        reg_rdata_o = '0;
        if (reg_addr_i == glb_addr(OFS_GSTAT)) reg_rdata_o = REG_W'(glb_stat);
        if (reg_addr_i == glb_addr(OFS_GEN))   reg_rdata_o = REG_W'(glb_en);
        if (reg_addr_i == glb_addr(OFS_SRC))   reg_rdata_o = src_word;
        if (reg_addr_i == glb_addr(OFS_MASK))  reg_rdata_o = mask_q;
        for (int p = 0; p < NPIPE; p++) begin
            if (reg_addr_i == pipe_addr(p, POFS_STAT)) reg_rdata_o = REG_W'(pipe_stat[p]);
            if (reg_addr_i == pipe_addr(p, POFS_EN))   reg_rdata_o = REG_W'(pipe_en[p]);
        end
    end

endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk
    import irq_agg_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_we_i,
    input logic [ADDR_W-1:0] reg_addr_i,
    input logic [GLB_W-1:0]  wdata_lo,
    input logic [GLB_W-1:0]  glb_evt_i,
    input logic [GLB_W-1:0]  glb_stat,
    input logic [REG_W-1:0]  src_word,
    input logic [REG_W-1:0]  mask_q,
    input logic              irq_o
);

    logic gclr;
    assign gclr = reg_we_i && (reg_addr_i == ADDR_W'(OFS_GCLR));

    // R8: output follows masked source with one edge of delay
    p_irq_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_o == $past(|(src_word & mask_q))));

    // R5: an event always lands, clear or not
    p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (glb_evt_i[4:1] != 4'd0) |=>
        ((glb_stat[4:1] & $past(glb_evt_i[4:1])) == $past(glb_evt_i[4:1])));

    // R4: write-one-to-clear removes the written bits when no event arrives
    p_w1c_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (gclr && glb_evt_i == '0) |=> ((glb_stat & $past(wdata_lo)) == '0));

    // R2: status bits are sticky without a clear
    p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !gclr |=> ((glb_stat & $past(glb_stat)) == $past(glb_stat)));

    // R7: global summary bit needs some pending global status
    p_src_glb_r7: assert property (@(posedge clk) disable iff (!rst_n)
        src_word[SRC_GLB_BIT] |-> (glb_stat != '0));

endmodule

bind irq_aggregator irq_aggregator_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_we_i   (reg_we_i),
    .reg_addr_i (reg_addr_i),
    .wdata_lo   (reg_wdata_i[4:0]),
    .glb_evt_i  (glb_evt_i),
    .glb_stat   (glb_stat),
    .src_word   (src_word),
    .mask_q     (mask_q),
    .irq_o      (irq_o)
);

// File: tb/sim_irq_aggregator.sv
module sim_irq_aggregator;

    localparam int NP = 4;
    localparam int PW = 6;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NP*PW-1:0] pipe_evt = '0;
    logic [4:0]     glb_evt = '0;
    logic           reg_we = 1'b0;
    logic [7:0]     reg_addr = '0;
    logic [31:0]    reg_wdata = '0;
    logic [31:0]    reg_rdata;
    logic           irq;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // reference model state
    logic [31:0] m_gstat = 0;
    logic [31:0] m_gen = 32'h6;
    logic [31:0] m_mask = 0;
    logic [31:0] m_pstat [NP];
    logic [31:0] m_pen [NP];
    logic        m_irq = 1'b0;

    irq_aggregator u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .pipe_evt_i  (pipe_evt),
        .glb_evt_i   (glb_evt),
        .reg_we_i    (reg_we),
        .reg_addr_i  (reg_addr),
        .reg_wdata_i (reg_wdata),
        .reg_rdata_o (reg_rdata),
        .irq_o       (irq)
    );

    always #4 clk = ~clk;

    function automatic logic [31:0] m_src();
        logic [31:0] s = 0;
        for (int p = 0; p < NP; p++) if ((m_pstat[p] & m_pen[p]) != 0) s[p] = 1'b1;
        if ((m_gstat & m_gen) != 0) s[31] = 1'b1;
        return s;
    endfunction

    function automatic logic [31:0] m_read(input int a);
        logic [31:0] r = 0;
        if (a == 0) r = m_gstat;
        if (a == 1) r = m_gen;
        if (a == 3) r = m_src();
        if (a == 4) r = m_mask;
        for (int p = 0; p < NP; p++) begin
            if (a == 16 + 4*p)     r = m_pstat[p];
            if (a == 16 + 4*p + 1) r = m_pen[p];
        end
        return r;
    endfunction

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic step(input string tag, input bit we, input int addr, input logic [31:0] wd,
                        input logic [31:0] pevt, input logic [31:0] gevt);
        logic nxt;
        reg_we    = we;
        reg_addr  = addr[7:0];
        reg_wdata = wd;
        pipe_evt  = pevt[NP*PW-1:0];
        glb_evt   = gevt[4:0];
        @(posedge clk);
        nxt = (m_src() & m_mask) != 0;
        if (we) begin
            if (addr == 1) m_gen = wd & 32'h1E;
            if (addr == 2) m_gstat = m_gstat & ~wd;
            if (addr == 4) m_mask = wd & 32'h8000000F;
            for (int p = 0; p < NP; p++) begin
                if (addr == 16 + 4*p + 1) m_pen[p] = wd & 32'h3F;
                if (addr == 16 + 4*p + 2) m_pstat[p] = m_pstat[p] & ~wd;
            end
        end
        m_gstat = m_gstat | (gevt & 32'h1E);
        for (int p = 0; p < NP; p++) m_pstat[p] = m_pstat[p] | ((pevt >> (PW*p)) & 32'h3F);
        m_irq = nxt;
        @(negedge clk);
        chk(tag, "irq", {31'b0, irq}, {31'b0, m_irq});
        chk(tag, "rdata", reg_rdata, m_read(addr));
        reg_we   = 1'b0;
        pipe_evt = '0;
        glb_evt  = '0;
    endtask

    task automatic rd(input string tag, input int addr);
        step(tag, 1'b0, addr, 0, 0, 0);
    endtask

    task automatic wr(input string tag, input int addr, input logic [31:0] wd);
        step(tag, 1'b1, addr, wd, 0, 0);
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int p = 0; p < NP; p++) begin
            m_pstat[p] = 0;
            m_pen[p] = 0;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values
        rd("R1", 1);
        chk("R1", "gen default", reg_rdata, 32'h6);
        chk("R1", "irq low", {31'b0, irq}, 32'h0);
        rd("R1", 0); rd("R1", 3); rd("R1", 4); rd("R1", 16); rd("R1", 21);

        // R2 pipe event latches while disabled
        step("R2", 1'b0, 20, 0, 32'h200, 0);
        chk("R2", "pipe1 stat", reg_rdata, 32'h08);
        rd("R2", 20);
        rd("R6", 3);
        chk("R6", "src disabled", reg_rdata, 32'h0);

        // R6 enable pipe1 bit3
        wr("R6", 21, 32'h08);
        rd("R6", 3);
        chk("R6", "src bit1", reg_rdata, 32'h2);

        // R8 mask and irq timing
        wr("R8", 4, 32'hFFFF_FFFF);
        chk("R8", "mask valid bits", reg_rdata, 32'h8000_000F);
        rd("R8", 3);
        chk("R8", "irq raised", {31'b0, irq}, 32'h1);
        rd("R8", 3); rd("R8", 3);

        // R4 write-one-to-clear
        wr("R4", 22, 32'h0);
        rd("R4", 20);
        chk("R4", "zero write keeps", reg_rdata, 32'h08);
        wr("R4", 22, 32'h08);
        rd("R4", 20);
        chk("R4", "cleared", reg_rdata, 32'h0);
        rd("R8", 3);
        chk("R8", "irq dropped", {31'b0, irq}, 32'h0);

        // R5 event and clear collide
        step("R5", 1'b1, 22, 32'h08, 32'h200, 0);
        rd("R5", 20);
        chk("R5", "event wins", reg_rdata, 32'h08);
        rd("R5", 3);

        // R3 global events, bit 0 ignored
        step("R3", 1'b0, 0, 0, 0, 32'h1F);
        chk("R3", "gstat", reg_rdata, 32'h1E);
        rd("R7", 3);
        chk("R7", "src bit31", reg_rdata[31], 1'b1);
        wr("R4", 2, 32'h06);
        rd("R4", 0);
        chk("R4", "global clear", reg_rdata, 32'h18);
        rd("R7", 3);
        chk("R7", "timer not enabled", {31'b0, reg_rdata[31]}, 32'h0);
        wr("R7", 1, 32'h1F);
        chk("R7", "gen writable bits", reg_rdata, 32'h1E);
        rd("R7", 3); rd("R7", 3);

        // R9 writes to read-only and unmapped addresses
        wr("R9", 0, 32'h0);
        rd("R9", 0);
        chk("R9", "gstat unchanged", reg_rdata, 32'h18);
        wr("R9", 3, 32'h0);
        wr("R9", 20, 32'h0);
        wr("R9", 23, 32'hFFFF_FFFF);
        wr("R9", 200, 32'hFFFF_FFFF);
        rd("R9", 20); rd("R9", 4); rd("R9", 2); rd("R9", 22);

        // R6 top pipe with all events
        step("R6", 1'b0, 28, 0, 32'h3F << 18, 0);
        wr("R6", 29, 32'h3F);
        rd("R6", 3);
        chk("R6", "src bit3", reg_rdata[3], 1'b1);
        wr("R4", 30, 32'h3F);
        wr("R4", 22, 32'h08);
        wr("R4", 2, 32'h1E);
        rd("R8", 3); rd("R8", 3);
        chk("R8", "all quiet", {31'b0, irq}, 32'h0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule